// File: doc/BRIEF.md
# Inter-Processor Interrupt Dispatch Sequencer

This block turns one request to interrupt a set of CPUs into the series of command-register writes that the interrupt delivery fabric expects. A request carries a bitmask of target CPUs, an interrupt vector and one of four addressing modes. The block also reads a static table that gives each CPU its 32-bit identifier. It then emits one or more write pulses on a command port. Each pulse carries a destination word, the vector and the mode actually used. While it works it keeps `req_ready` low. When the last write is complete it raises `done` for one cycle.

The modes differ in how many writes a request needs and in how the writes are paced. The 8-bit bitmap mode reaches up to eight CPUs with a single write. The two physical modes need one write per target. The clustered extended mode needs one write per distinct cluster. The two legacy-format modes wait for the fabric's busy flag to clear after every write. The extended modes issue writes on back-to-back cycles. Targets are always served in ascending CPU index order, so the write sequence is fully determined by the request and the identifier table.

Top module: `ipi_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `cmd_valid` and `done` are 0.
- R2: Mode 0 (8-bit bitmap) with targets only among CPUs 0..7 gives exactly one write. Its destination is the mask in bits 7:0 and zero in bits 31:8, and `cmd_mode` is 0.
- R3: Mode 0 with any target at CPU index 8 or above is served exactly as mode 1, and every write reports `cmd_mode` 1.
- R4: Modes 1 and 2 give one write per target in ascending CPU index. The mode 1 destination is bits 7:0 of that CPU's identifier, zero-extended. The mode 2 destination is the full 32-bit identifier.
- R5: In modes 0 and 1, after each write the next write (or `done`) comes no earlier than two cycles later. It comes in the cycle after the first cycle, from the one following the write onward, in which `dlv_busy` is sampled 0.
- R6: In mode 2, successive writes occupy consecutive cycles whatever `dlv_busy` does.
- R7: In mode 3, a CPU's cluster is identifier bits 19:4 and its bitmap position is identifier bits 3:0. Each write carries the cluster in bits 31:16 and the OR of its targets' bitmap bits in bits 15:0. There is one write per distinct cluster, ordered by the lowest pending CPU index in each cluster. Mode 3 writes are back to back.
- R8: Every write carries the vector of the accepted request.
- R9: `done` is a single-cycle pulse. It comes one cycle after the last write in modes 2 and 3, and after the busy wait of R5 in modes 0 and 1. It comes in the cycle after acceptance, with no write, for an empty mask.
- R10: A request is accepted only when `req_ready` is 1. `req_ready` is 0 from the cycle after acceptance through the `done` cycle. A request presented while `req_ready` is 0 changes no write and is never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_mask | input | NCPU | Target CPU bitmask |
| req_vector | input | VEC_W | Interrupt vector |
| req_mode | input | 2 | 0 bitmap-8, 1 legacy physical, 2 extended physical, 3 extended clustered |
| id_table | input | NCPU*32 | Per-CPU identifiers, CPU i at bits 32*i+31:32*i |
| cmd_valid | output | 1 | Command write pulse |
| cmd_dest | output | 32 | Destination word of the write |
| cmd_vector | output | VEC_W | Vector of the write |
| cmd_mode | output | 2 | Mode used for the write |
| dlv_busy | input | 1 | Delivery busy flag |
| done | output | 1 | Request complete pulse |

## Verification
Two things can fall in the same cycle. A new request can arrive while a sequence is still running, including during the `done` cycle. The busy flag can also clear in the cycle right after a legacy write. The bench holds a conflicting request high from mid-sequence through the `done` cycle and expects the original write list, unchanged, followed by an idle cycle with no write. The busy delay of the bench's fabric model is swept from 0 to 3 cycles, so the busy flag is sometimes already clear at the first poll. In each case the bench judges the exact write cycles against a gap of delay plus two.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int ID_W   = 32;
  localparam int DEST_W = 32;
  localparam int CL_W   = 16;
  localparam int BM_W   = 16;

  typedef enum logic [1:0] {
    MODE_BMAP8 = 2'd0,
    MODE_PHY8  = 2'd1,
    MODE_PHYX  = 2'd2,
    MODE_CLUX  = 2'd3
  } ipi_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_POLL  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;

  function automatic logic needs_poll(input ipi_mode_e m);
    return (m == MODE_BMAP8) || (m == MODE_PHY8);
  endfunction

  function automatic ipi_mode_e resolve_mode(input ipi_mode_e m, input logic wide_target);
    if (m == MODE_BMAP8 && wide_target) return MODE_PHY8;
    return m;
  endfunction

  function automatic logic [CL_W-1:0] cluster_of(input logic [ID_W-1:0] id);
    return id[19:4];
  endfunction

  function automatic logic [3:0] lbit_of(input logic [ID_W-1:0] id);
    return id[3:0];
  endfunction

  function automatic logic [DEST_W-1:0] phy8_dest(input logic [ID_W-1:0] id);
    return {24'd0, id[7:0]};
  endfunction

endpackage

// File: rtl/ipi_lead_pick.sv
module ipi_lead_pick #(
  parameter int NCPU  = 16,
  localparam int IDX_W = $clog2(NCPU)
) (
  input  logic [NCPU-1:0]  pend,
  output logic [NCPU-1:0]  onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = NCPU - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
    any    = |pend;
    onehot = any ? ({{(NCPU-1){1'b0}}, 1'b1} << idx) : '0;
  end
endmodule

// File: rtl/ipi_cluster_group.sv
module ipi_cluster_group
  import ipi_pkg::*;
#(
  parameter int NCPU  = 16,
  localparam int IDX_W = $clog2(NCPU)
) (
  input  logic [NCPU-1:0]      pend,
  input  logic [NCPU*ID_W-1:0] ids,
  input  logic [IDX_W-1:0]     lead_idx,
  output logic [NCPU-1:0]      grp,
  output logic [CL_W-1:0]      lead_cl,
  output logic [BM_W-1:0]      bitmap
);
  assign lead_cl = cluster_of(ids[lead_idx*ID_W +: ID_W]);

  for (genvar g = 0; g < NCPU; g++) begin : g_match
    assign grp[g] = pend[g] && (cluster_of(ids[g*ID_W +: ID_W]) == lead_cl);
  end

  always_comb begin
    bitmap = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (grp[i]) bitmap[lbit_of(ids[i*ID_W +: ID_W])] = 1'b1;
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NCPU  = 16,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [NCPU-1:0]      req_mask,
  input  logic [VEC_W-1:0]     req_vector,
  input  logic [1:0]           req_mode,
  input  logic [NCPU*32-1:0]   id_table,
  output logic                 cmd_valid,
  output logic [31:0]          cmd_dest,
  output logic [VEC_W-1:0]     cmd_vector,
  output logic [1:0]           cmd_mode,
  input  logic                 dlv_busy,
  output logic                 done
);
  localparam int IDX_W = $clog2(NCPU);
  localparam int LOW_N = (NCPU < 8) ? NCPU : 8;

  seq_state_e         st_q;
  logic [NCPU-1:0]    pend_q;
  logic [VEC_W-1:0]   vec_q;
  ipi_mode_e          mode_q;

  // named internal events, also used by the bound checker
  logic               accept_w;
  logic               issue_w;
  logic               poll_st;
  logic               last_w;
  logic               wide_w;

  logic [NCPU-1:0]    lead_oh;
  logic [IDX_W-1:0]   lead_idx;
  logic               lead_any;
  logic [NCPU-1:0]    grp;
  logic [CL_W-1:0]    lead_cl;
  logic [BM_W-1:0]    grp_bm;
  logic [NCPU-1:0]    clr_w;
  logic [NCPU-1:0]    pend_nx;
  logic [7:0]         low8;
  logic [ID_W-1:0]    lead_id;

  if (NCPU > 8) begin : g_wide
    assign wide_w = |req_mask[NCPU-1:8];
  end else begin : g_narrow
    assign wide_w = 1'b0;
  end

  always_comb begin
    low8 = '0;
    low8[LOW_N-1:0] = pend_q[LOW_N-1:0];
  end

  ipi_lead_pick #(.NCPU(NCPU)) u_pick (
    .pend   (pend_q),
    .onehot (lead_oh),
    .idx    (lead_idx),
    .any    (lead_any)
  );

  ipi_cluster_group #(.NCPU(NCPU)) u_group (
    .pend     (pend_q),
    .ids      (id_table),
    .lead_idx (lead_idx),
    .grp      (grp),
    .lead_cl  (lead_cl),
    .bitmap   (grp_bm)
  );

  assign lead_id   = id_table[lead_idx*ID_W +: ID_W];
  assign accept_w  = req_valid && (st_q == ST_IDLE);
  assign issue_w   = (st_q == ST_ISSUE) && lead_any;
  assign poll_st   = (st_q == ST_POLL);

  always_comb begin
    unique case (mode_q)
      MODE_BMAP8: begin cmd_dest = {24'd0, low8};     clr_w = pend_q;  end
      MODE_PHY8:  begin cmd_dest = phy8_dest(lead_id); clr_w = lead_oh; end
      MODE_PHYX:  begin cmd_dest = lead_id;           clr_w = lead_oh; end
      default:    begin cmd_dest = {lead_cl, grp_bm}; clr_w = grp;     end
    endcase
  end

  assign pend_nx    = pend_q & ~clr_w;
  assign last_w     = (pend_nx == '0);
  assign cmd_valid  = issue_w;
  assign cmd_vector = vec_q;
  assign cmd_mode   = mode_q;
  assign req_ready  = (st_q == ST_IDLE);
  assign done       = (st_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      vec_q  <= '0;
      mode_q <= MODE_BMAP8;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept_w) begin
          pend_q <= req_mask;
          vec_q  <= req_vector;
          mode_q <= resolve_mode(ipi_mode_e'(req_mode), wide_w);
          st_q   <= (req_mask == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: begin
          pend_q <= pend_nx;
          if (needs_poll(mode_q)) st_q <= ST_POLL;
          else if (last_w)        st_q <= ST_FIN;
        end
        ST_POLL: if (!dlv_busy) st_q <= (pend_q == '0) ? ST_FIN : ST_ISSUE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             cmd_valid,
  input logic [31:0]      cmd_dest,
  input logic [VEC_W-1:0] cmd_vector,
  input logic [1:0]       cmd_mode,
  input logic             dlv_busy,
  input logic             done,
  input logic             poll_st,
  input logic             last_w
);
  assert_no_write_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !req_ready));

  assert_legacy_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode < 2'd2) |=> !cmd_valid);

  assert_poll_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_st && dlv_busy) |=> (!cmd_valid && !done));

  assert_ext_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'd2 && !last_w) |=> cmd_valid);

  assert_bitmap_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'd0) |-> (cmd_dest[31:8] == 24'd0 && cmd_dest[7:0] != 8'd0));

  assert_cluster_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'd3) |-> (cmd_dest[15:0] != 16'd0));

  assert_vector_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && $past(cmd_valid)) |-> $stable(cmd_vector));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .cmd_valid  (cmd_valid),
  .cmd_dest   (cmd_dest),
  .cmd_vector (cmd_vector),
  .cmd_mode   (cmd_mode),
  .dlv_busy   (dlv_busy),
  .done       (done),
  .poll_st    (poll_st),
  .last_w     (last_w)
);

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [N-1:0] req_mask = '0;
  logic [7:0] req_vector = '0;
  logic [1:0] req_mode = '0;
  logic [N*32-1:0] id_table;
  logic cmd_valid;
  logic [31:0] cmd_dest;
  logic [7:0] cmd_vector;
  logic [1:0] cmd_mode;
  logic dlv_busy;
  logic done;

  int n_chk = 0, n_bad = 0, cyc = 0, busy_dly = 0, busy_cnt = 0;
  logic [31:0] e_dest [0:15];
  int e_n, e_mode;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // delivery fabric model: busy for busy_dly cycles after each write
  always @(posedge clk) begin
    if (!rst_n) busy_cnt <= 0;
    else if (cmd_valid) busy_cnt <= busy_dly;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign dlv_busy = (busy_cnt != 0);

  ipi_dispatch #(.NCPU(N), .VEC_W(8)) i_ipi_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_vector(req_vector), .req_mode(req_mode),
    .id_table(id_table), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_vector(cmd_vector), .cmd_mode(cmd_mode), .dlv_busy(dlv_busy), .done(done)
  );

  function automatic logic [31:0] bid(input int i);
    return 32'hA0000 | ((i % 3) << 4) | i;
  endfunction

  initial for (int i = 0; i < N; i++) id_table[i*32 +: 32] = bid(i);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_exp(input logic [N-1:0] m, input int md);
    logic [N-1:0] rem;
    e_n = 0;
    e_mode = (md == 0 && m[N-1:8] != 0) ? 1 : md;
    rem = m;
    if (m == 0) return;
    if (e_mode == 0) begin
      e_dest[0] = {24'd0, m[7:0]};
      e_n = 1;
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (rem[i]) begin
        if (e_mode == 1) begin e_dest[e_n] = bid(i) & 32'hFF; rem[i] = 1'b0; end
        else if (e_mode == 2) begin e_dest[e_n] = bid(i); rem[i] = 1'b0; end
        else begin
          logic [15:0] bm;
          bm = '0;
          for (int j = 0; j < N; j++) begin
            if (rem[j] && bid(j)[19:4] == bid(i)[19:4]) begin
              bm[bid(j) & 15] = 1'b1;
              rem[j] = 1'b0;
            end
          end
          e_dest[e_n] = {bid(i)[19:4], bm};
        end
        e_n++;
      end
    end
  endtask

  task automatic run_req(input logic [N-1:0] m, input logic [7:0] v, input int md,
                         input int dly, input bit inject);
    int acc, n, gap, next_cyc, done_cyc, tries;
    bit seen_done;
    string dtag;
    build_exp(m, md);
    gap = (e_mode < 2) ? dly + 2 : 1;
    dtag = (e_mode == 0) ? "R2" : (e_mode == 3) ? "R7" : (md == 0) ? "R3" : "R4";
    @(negedge clk);
    busy_dly = dly;
    req_valid = 1'b1; req_mask = m; req_vector = v; req_mode = 2'(md);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    n = 0; seen_done = 0; done_cyc = -1; tries = 0;
    next_cyc = acc;
    while (!seen_done && tries < 400) begin
      if (inject && tries == 1) begin
        req_valid = 1'b1; req_mask = ~m; req_vector = ~v; req_mode = 2'd2;
      end
      if (req_ready) chk(0, "R10 ready during sequence", 1, 0);
      if (cmd_valid) begin
        if (n < e_n) begin
          chk(cmd_dest == e_dest[n], dtag, cmd_dest, e_dest[n]);
          chk(cmd_mode == 2'(e_mode), (md == 0 && e_mode == 1) ? "R3 mode" : "R2 mode", 32'(cmd_mode), 32'(e_mode));
          chk(cmd_vector == v, "R8 vector", 32'(cmd_vector), 32'(v));
          chk(cyc == next_cyc, (e_mode < 2) ? "R5 write cycle" : (e_mode == 2) ? "R6 write cycle" : "R7 write cycle",
              32'(cyc - acc), 32'(next_cyc - acc));
        end
        n++;
        next_cyc = cyc + gap;
      end
      if (done) begin
        seen_done = 1; done_cyc = cyc;
      end else begin
        @(negedge clk);
        tries++;
      end
    end
    req_valid = 1'b0;
    chk(n == e_n, (e_mode == 0) ? "R2 write count" : (e_mode == 3) ? "R7 write count" : "R4 write count", 32'(n), 32'(e_n));
    if (e_n == 0) chk(done_cyc == acc, "R9 empty done", 32'(done_cyc - acc), 0);
    else chk(done_cyc == next_cyc, "R9 done cycle", 32'(done_cyc - acc), 32'(next_cyc - acc));
    @(negedge clk);
    chk(req_ready && !done && !cmd_valid, "R10 idle after done", {29'd0, req_ready, done, cmd_valid}, 32'h4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1 during reset", {29'd0, req_ready, cmd_valid, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !done, "R1 after reset", {29'd0, req_ready, cmd_valid, done}, 32'h4);
    // conflicting request held from mid-sequence through done (R10)
    run_req(10'h3FF, 8'h5A, 1, 2, 1'b1);
    run_req(10'h2B5, 8'hC3, 3, 0, 1'b1);
    run_req(10'h0F1, 8'h11, 0, 3, 1'b1);
    for (int md = 0; md < 4; md++) begin
      for (int m = 0; m < (1 << N); m++) begin
        run_req(N'(m), 8'((m * 7 + md) & 8'hFF), md, m % 4, 1'b0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule